// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Front End

This block is the bus-facing slave logic of a digitally controlled potentiometer. It watches the two bus lines, SCL and SDA, after passing them through synchronizers clocked by a fast system clock. It finds start and stop conditions, checks the identification byte against a fixed type code and three address pins, and decodes the instruction byte. That byte carries an opcode, a register index and a bank index. The block then hands work to the register file and the wiper counter through one-cycle strobes.

Frames are either two bytes long (transfers between the wiper and a data register) or three bytes long (wiper or data-register read and write). On reads the block drives the byte supplied by the back end onto the open-drain SDA output. On writes it captures the master's byte. In increment/decrement mode every further SCL pulse becomes a one-step strobe, and the SDA level during that pulse gives the direction. While the back end is busy with a nonvolatile write, the identification byte is not acknowledged, so the master can poll until the write completes.

Top module: `dpot_cmd_front`

## Requirements
- R1: After reset the SDA pull-down is released and neither the command strobe nor the step strobe is active.
- R2: The identification byte, sent MSB first, is acknowledged only when bits 7:4 equal 0101, bit 3 is 0 and bits 2:0 equal the address pins. The acknowledge pulls SDA low for the ninth clock. A mismatch leaves SDA released and ignores the rest of the frame.
- R3: While busy is high when the last identification bit is sampled, no acknowledge is given and no strobe results from the frame.
- R4: The instruction byte is opcode[7:4], register[3:2], bank[1:0]. The legal opcodes are 1001 (read wiper), 1010 (write wiper), 1011 (read data register), 1100 (write data register), 1101 (data register to wiper), 1110 (wiper to data register) and 0010 (step mode). An illegal opcode, or a nonzero bank with any opcode other than 1011 and 1100, gets no acknowledge and no strobe.
- R5: The data-register read and write opcodes are accepted for every bank value, and that bank is reported with the strobe.
- R6: For 1001 and 1011 the command strobe is issued when the last instruction bit is sampled. After the acknowledge, the read-data byte is shifted out MSB first, and the SDA pull-down changes only while SCL is low.
- R7: For 1010 and 1100 the third byte is captured MSB first. The strobe carries it once its eighth bit is sampled, and the byte is acknowledged.
- R8: For 1101 and 1110 the strobe is issued when the last instruction bit is sampled, and later bits before the stop are ignored.
- R9: In step mode each complete SCL pulse after the instruction acknowledge yields one step strobe on the falling SCL edge. The step is upward if SDA was high at the rising edge. A pulse that ends in a stop yields no step.
- R10: A start or stop in the middle of a frame aborts it with no strobe. A repeated start begins a new identification byte.
- R11: Each strobe lasts one system-clock cycle, and the command and step strobes never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pins_i | input | 3 | Strapped slave address |
| busy_i | input | 1 | Back end busy with a nonvolatile write |
| rd_data_i | input | 8 | Byte to send on reads, valid after the read strobe |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the command |
| cmd_reg_o | output | 2 | Register index |
| cmd_bank_o | output | 2 | Bank index |
| wr_data_o | output | 8 | Captured byte for write commands |
| step_valid_o | output | 1 | One-cycle step strobe |
| step_up_o | output | 1 | Step direction, 1 = upward |

## Verification
The main collision is a stop condition and a pending step. The last SCL rise before a stop arms a step, and a stop inside the same high phase must cancel it. This also holds when the repeated start of an aborted write lands on a cycle where a bit is being sampled. The bench ends a run of up and down pulses with a stop, and aborts a write halfway through its data byte with a repeated start. A scoreboard of expected strobes then judges both cases: any extra step or write strobe, or any item left unconsumed, counts as a failure.

// File: rtl/dpot_cmd_pkg.sv
package dpot_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int REG_W  = 2;
  localparam int BANK_W = 2;

  localparam logic [OP_W-1:0] OP_RD_WIPER  = 4'b1001;
  localparam logic [OP_W-1:0] OP_WR_WIPER  = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_DREG   = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_DREG   = 4'b1100;
  localparam logic [OP_W-1:0] OP_DREG_WIPE = 4'b1101;
  localparam logic [OP_W-1:0] OP_WIPE_DREG = 4'b1110;
  localparam logic [OP_W-1:0] OP_STEP      = 4'b0010;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ID_RX,
    PH_ID_ACK,
    PH_INS_RX,
    PH_INS_ACK,
    PH_DAT_RX,
    PH_DAT_ACK,
    PH_DAT_TX,
    PH_STEP,
    PH_WAIT_STOP
  } phase_e;

  function automatic logic op_allowed(input logic [OP_W-1:0] op,
                                      input logic [BANK_W-1:0] bank);
    logic ok;
    case (op)
      OP_RD_DREG, OP_WR_DREG: ok = 1'b1;
      OP_RD_WIPER, OP_WR_WIPER, OP_DREG_WIPE,
      OP_WIPE_DREG, OP_STEP:  ok = (bank == '0);
      default:                ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_DREG);
  endfunction

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return (op == OP_WR_WIPER) || (op == OP_WR_DREG);
  endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int          WIDTH     = 2,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RESET_VAL;
    else        stage_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RESET_VAL;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dpot_bus_edges.sv
module dpot_bus_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/dpot_frame_ctrl.sv
module dpot_frame_ctrl
  import dpot_cmd_pkg::*;
#(
  parameter int                  ADDR_W  = 3,
  parameter logic [BYTE_W-ADDR_W-2:0] TYPE_ID = 4'b0101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_level,
  input  logic                sda_bit,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [ADDR_W-1:0]   addr_pins,
  input  logic                busy,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                sda_pull,
  output logic                cmd_valid,
  output logic [OP_W-1:0]     cmd_op,
  output logic [REG_W-1:0]    cmd_reg,
  output logic [BANK_W-1:0]   cmd_bank,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                step_valid,
  output logic                step_up
);

  localparam int TYPE_W = BYTE_W - ADDR_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e              state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   shift_q, shift_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic                pull_q, pull_d;
  logic                armed_q, armed_d;
  logic                dir_q, dir_d;
  logic [OP_W-1:0]     op_q, op_d;
  logic [REG_W-1:0]    reg_q, reg_d;
  logic [BANK_W-1:0]   bank_q, bank_d;
  logic                cmd_valid_q, cmd_valid_d;
  logic [BYTE_W-1:0]   wr_data_q, wr_data_d;
  logic                step_valid_q, step_valid_d;
  logic                step_up_q, step_up_d;

  logic [BYTE_W-1:0]   byte_in;
  logic                last_bit;
  logic                id_match;
  logic [OP_W-1:0]     ins_op;
  logic [BANK_W-1:0]   ins_bank;

  always_comb begin
    byte_in  = {shift_q[BYTE_W-2:0], sda_bit};
    last_bit = (cnt_q == LAST_BIT);
    id_match = (byte_in[BYTE_W-1 -: TYPE_W] == TYPE_ID) &&
               (byte_in[ADDR_W] == 1'b0) &&
               (byte_in[ADDR_W-1:0] == addr_pins);
    ins_op   = byte_in[BYTE_W-1 -: OP_W];
    ins_bank = byte_in[BANK_W-1:0];
  end

  // next-state logic
  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    shift_d      = shift_q;
    tx_d         = tx_q;
    pull_d       = pull_q;
    armed_d      = armed_q;
    dir_d        = dir_q;
    op_d         = op_q;
    reg_d        = reg_q;
    bank_d       = bank_q;
    wr_data_d    = wr_data_q;
    cmd_valid_d  = 1'b0;
    step_valid_d = 1'b0;
    step_up_d    = step_up_q;

    if (stop_det) begin
      state_d = PH_IDLE;
      pull_d  = 1'b0;
      armed_d = 1'b0;
    end else if (start_det) begin
      state_d = PH_ID_RX;
      cnt_d   = '0;
      pull_d  = 1'b0;
      armed_d = 1'b0;
    end else begin
      unique case (state_q)
        PH_IDLE, PH_WAIT_STOP: ;

        PH_ID_RX: begin
          if (scl_rise) begin
            shift_d = byte_in;
            cnt_d   = cnt_q + 1'b1;
            if (last_bit) begin
              armed_d = 1'b0;
              state_d = (id_match && !busy) ? PH_ID_ACK : PH_IDLE;
            end
          end
        end

        PH_INS_RX: begin
          if (scl_rise) begin
            shift_d = byte_in;
            cnt_d   = cnt_q + 1'b1;
            if (last_bit) begin
              armed_d = 1'b0;
              if (op_allowed(ins_op, ins_bank)) begin
                op_d    = ins_op;
                reg_d   = byte_in[BANK_W +: REG_W];
                bank_d  = ins_bank;
                state_d = PH_INS_ACK;
                cmd_valid_d = (ins_op != OP_STEP) && !op_is_write(ins_op);
              end else begin
                state_d = PH_IDLE;
              end
            end
          end
        end

        PH_DAT_RX: begin
          if (scl_rise) begin
            shift_d = byte_in;
            cnt_d   = cnt_q + 1'b1;
            if (last_bit) begin
              wr_data_d   = byte_in;
              cmd_valid_d = 1'b1;
              armed_d     = 1'b0;
              state_d     = PH_DAT_ACK;
            end
          end
        end

        PH_ID_ACK, PH_INS_ACK, PH_DAT_ACK: begin
          if (scl_fall) begin
            if (!armed_q) begin
              pull_d  = 1'b1;
              armed_d = 1'b1;
            end else begin
              pull_d  = 1'b0;
              armed_d = 1'b0;
              cnt_d   = '0;
              if (state_q == PH_ID_ACK) begin
                state_d = PH_INS_RX;
              end else if (state_q == PH_DAT_ACK) begin
                state_d = PH_WAIT_STOP;
              end else if (op_is_read(op_q)) begin
                tx_d    = rd_data;
                pull_d  = ~rd_data[BYTE_W-1];
                state_d = PH_DAT_TX;
              end else if (op_is_write(op_q)) begin
                state_d = PH_DAT_RX;
              end else if (op_q == OP_STEP) begin
                state_d = PH_STEP;
              end else begin
                state_d = PH_WAIT_STOP;
              end
            end
          end
        end

        PH_DAT_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == '0) begin
              pull_d  = 1'b0;
              state_d = PH_WAIT_STOP;
            end else begin
              pull_d = ~tx_q[LAST_BIT - cnt_q];
            end
          end
        end

        PH_STEP: begin
          if (scl_rise) begin
            dir_d   = sda_bit;
            armed_d = 1'b1;
          end else if (scl_fall && armed_q) begin
            step_valid_d = 1'b1;
            step_up_d    = dir_q;
            armed_d      = 1'b0;
          end
        end

        default: state_d = PH_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= PH_IDLE;
      cnt_q        <= '0;
      shift_q      <= '0;
      tx_q         <= '0;
      pull_q       <= 1'b0;
      armed_q      <= 1'b0;
      dir_q        <= 1'b0;
      op_q         <= '0;
      reg_q        <= '0;
      bank_q       <= '0;
      cmd_valid_q  <= 1'b0;
      wr_data_q    <= '0;
      step_valid_q <= 1'b0;
      step_up_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      shift_q      <= shift_d;
      tx_q         <= tx_d;
      pull_q       <= pull_d;
      armed_q      <= armed_d;
      dir_q        <= dir_d;
      op_q         <= op_d;
      reg_q        <= reg_d;
      bank_q       <= bank_d;
      cmd_valid_q  <= cmd_valid_d;
      wr_data_q    <= wr_data_d;
      step_valid_q <= step_valid_d;
      step_up_q    <= step_up_d;
    end
  end

  assign sda_pull   = pull_q;
  assign cmd_valid  = cmd_valid_q;
  assign cmd_op     = op_q;
  assign cmd_reg    = reg_q;
  assign cmd_bank   = bank_q;
  assign wr_data    = wr_data_q;
  assign step_valid = step_valid_q;
  assign step_up    = step_up_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_q && step_valid_q));

  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_q |=> !cmd_valid_q);

  // R4
  bank_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_q && !(op_q == OP_RD_DREG || op_q == OP_WR_DREG)) |-> (bank_q == '0));

  // R6
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_level);

  // R9
  step_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_q |-> (op_q == OP_STEP));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!pull_q && !step_valid_q));

endmodule

// File: rtl/dpot_cmd_front.sv
module dpot_cmd_front
  import dpot_cmd_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-ADDR_W-2:0] TYPE_ID = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] addr_pins_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic [OP_W-1:0]   cmd_op_o,
  output logic [REG_W-1:0]  cmd_reg_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              step_valid_o,
  output logic              step_up_o
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;
  logic [1:0]            bus_s;
  logic                  scl_rise, scl_fall, start_det, stop_det;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  dpot_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (bus_s)
  );

  dpot_bus_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  dpot_frame_ctrl #(.ADDR_W(ADDR_W), .TYPE_ID(TYPE_ID)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .scl_level  (bus_s[1]),
    .sda_bit    (bus_s[0]),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .addr_pins  (addr_pins_i),
    .busy       (busy_i),
    .rd_data    (rd_data_i),
    .sda_pull   (sda_pull_o),
    .cmd_valid  (cmd_valid_o),
    .cmd_op     (cmd_op_o),
    .cmd_reg    (cmd_reg_o),
    .cmd_bank   (cmd_bank_o),
    .wr_data    (wr_data_o),
    .step_valid (step_valid_o),
    .step_up    (step_up_o)
  );

endmodule

// File: tb/tb_dpot_cmd_front.sv
`timescale 1ns/1ps
module tb_dpot_cmd_front;

  localparam int Q = 12;          // SCL half period in system clocks
  localparam logic [2:0] MY_ADDR = 3'b101;
  localparam logic [7:0] ID_OK   = 8'h55;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       busy;
  logic [7:0] rd_val;
  logic       sda_pull, cmd_valid, step_valid, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_bank;
  logic [7:0] wr_data;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic edge_bad = 1'b0;
  logic [17:0] exp_q[$];   // {kind, up, op[3:0], reg[1:0], bank[1:0], data[7:0]}

  always #4 clk = ~clk;    // 125 MHz

  assign sda_bus = sda_m & ~sda_pull;

  dpot_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .addr_pins_i(MY_ADDR), .busy_i(busy),
    .rd_data_i(rd_val), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_reg_o(cmd_reg), .cmd_bank_o(cmd_bank), .wr_data_o(wr_data),
    .step_valid_o(step_valid), .step_up_o(step_up)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [3:0] op, input logic [1:0] rg,
                          input logic [1:0] bk, input logic [7:0] d);
    exp_q.push_back({1'b0, 1'b0, op, rg, bk, d});
  endtask

  task automatic push_step(input logic up);
    exp_q.push_back({1'b1, up, 16'h0});
  endtask

  // scoreboard monitor
  logic prev_cmd = 1'b0, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m && (sda_pull != prev_pull)) edge_bad = 1'b1;
      if (cmd_valid && prev_cmd) chk("R11 command strobe width", 2, 1);
      if (cmd_valid && step_valid) chk("R11 strobes coincide", 1, 0);
      else if (cmd_valid || step_valid) begin
        if (exp_q.size() == 0) begin
          chk("R10 unexpected strobe", {cmd_valid, step_valid}, 0);
        end else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          if (e[17]) begin
            chk("R9 step kind", step_valid, 1);
            chk("R9 step direction", step_up, e[16]);
          end else begin
            chk("R4 command kind", cmd_valid, 1);
            chk("R4 command fields", {cmd_op, cmd_reg, cmd_bank}, e[15:8]);
            if (e[15:12] == 4'b1010 || e[15:12] == 4'b1100)
              chk("R7 write data", wr_data, e[7:0]);
          end
        end
      end
      prev_cmd  = cmd_valid;
      prev_pull = sda_pull;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    end
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q/2);
  endtask

  task automatic bus_stop();
    wq(Q/2); sda_m = 1'b0; wq(Q/2); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    wq(Q/2); sda_m = b; wq(Q/2); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic v);
    wq(Q/2); sda_m = 1'b1; wq(Q/2); scl_m = 1'b1; wq(Q/2); v = sda_bus;
    wq(Q/2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(v);
    ack = ~v;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(v);
      b[i] = v;
    end
    send_bit(nack);
  endtask

  task automatic frame_hdr(input logic [7:0] id, input logic [7:0] ins,
                           output logic a_id, output logic a_ins);
    bus_start();
    send_byte(id, a_id);
    a_ins = 1'b0;
    if (a_id) send_byte(ins, a_ins);
  endtask

  task automatic write_frame(input logic [7:0] ins, input logic [7:0] d);
    logic a1, a2, a3;
    push_cmd(ins[7:4], ins[3:2], ins[1:0], d);
    frame_hdr(ID_OK, ins, a1, a2);
    chk("R2 id ack on write", a1, 1);
    chk("R7 instruction ack on write", a2, 1);
    send_byte(d, a3);
    chk("R7 data byte ack", a3, 1);
    bus_stop();
  endtask

  task automatic read_frame(input logic [7:0] ins, input logic [7:0] d);
    logic a1, a2;
    logic [7:0] got;
    rd_val = d;
    push_cmd(ins[7:4], ins[3:2], ins[1:0], 8'h00);
    frame_hdr(ID_OK, ins, a1, a2);
    chk("R6 instruction ack on read", a2, 1);
    recv_byte(got, 1'b1);
    chk("R6 read byte", got, d);
    bus_stop();
  endtask

  task automatic reject_frame(input logic [7:0] id, input logic [7:0] ins,
                              input logic exp_id, input string tag);
    logic a1, a2;
    frame_hdr(id, ins, a1, a2);
    chk(tag, {a1, a2}, {exp_id, 1'b0});
    bus_stop();
  endtask

  initial begin
    logic a1, a2;
    scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; rd_val = 8'h00;
    rst_n = 1'b0;
    wq(10);
    rst_n = 1'b1;
    wq(10);
    // R1 reset state
    chk("R1 released after reset", sda_pull, 0);
    chk("R1 no strobe after reset", {cmd_valid, step_valid}, 0);

    // R2 identification mismatches
    reject_frame(8'h75, 8'hA0, 1'b0, "R2 wrong type nibble");
    reject_frame(8'h54, 8'hA0, 1'b0, "R2 wrong address");
    reject_frame(8'h5D, 8'hA0, 1'b0, "R2 bit 3 set");

    // R10 stop in the middle of the instruction byte
    bus_start();
    send_byte(ID_OK, a1);
    chk("R2 id ack", a1, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();

    // R7 and R5 writes
    write_frame(8'hA0, 8'h5A);
    write_frame(8'hCB, 8'hC3);

    // R6 and R5 reads
    read_frame(8'h90, 8'hA7);
    read_frame(8'hB6, 8'h3C);

    // R8 transfers, trailing bits ignored
    push_cmd(4'hE, 2'd1, 2'd0, 8'h00);
    frame_hdr(ID_OK, 8'hE4, a1, a2);
    chk("R8 transfer to register ack", a2, 1);
    send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    push_cmd(4'hD, 2'd3, 2'd0, 8'h00);
    frame_hdr(ID_OK, 8'hDC, a1, a2);
    chk("R8 transfer to wiper ack", a2, 1);
    bus_stop();

    // R4 illegal opcode and bank combinations
    reject_frame(ID_OK, 8'h00, 1'b1, "R4 illegal opcode");
    reject_frame(ID_OK, 8'hA1, 1'b1, "R4 wiper write on bank 1");
    reject_frame(ID_OK, 8'hE2, 1'b1, "R4 transfer on bank 2");

    // R3 busy withholds the acknowledge
    busy = 1'b1;
    reject_frame(ID_OK, 8'hA0, 1'b0, "R3 busy polling");
    busy = 1'b0;
    write_frame(8'hA0, 8'h11);

    // R9 step mode ending in a stop
    frame_hdr(ID_OK, 8'h20, a1, a2);
    chk("R9 step mode ack", a2, 1);
    push_step(1'b1); send_bit(1'b1);
    push_step(1'b1); send_bit(1'b1);
    push_step(1'b0); send_bit(1'b0);
    push_step(1'b1); send_bit(1'b1);
    bus_stop();

    // R10 repeated start aborts a write
    frame_hdr(ID_OK, 8'hCC, a1, a2);
    chk("R10 write start ack", a2, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    push_cmd(4'hD, 2'd1, 2'd0, 8'h00);
    frame_hdr(ID_OK, 8'hD4, a1, a2);
    chk("R10 id ack after repeated start", a1, 1);
    chk("R10 instruction ack after repeated start", a2, 1);
    bus_stop();

    wq(20);
    chk("R10 all expected strobes seen", exp_q.size(), 0);
    chk("R6 pull changes only with SCL low", edge_bad, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule